// File: doc/BRIEF.md
# Parallel Integer Square Root Array

This block computes the integer square root of an unsigned number in a single combinational pass. There is no clock, no state and no handshake: the root appears at the output as soon as the input settles through the array. With the default parameters an 8-bit input yields a 4-bit root. Setting the input width to 32 yields a 16-bit root from the same structure, with more rows added.

The array has one row per root bit, and the most significant bit is resolved first. Each row subtracts a trial value from the running remainder. The trial value is the root bits found so far, followed by the bit pair 0 then 1, aligned to the row's bit weight. The final borrow of the row decides the outcome. If there is no borrow, the root bit is 1 and the difference becomes the new remainder. If there is a borrow, the root bit is 0 and the remainder passes through unchanged.

Each row is a chain of identical subtract-and-select cells. Cells whose trial bit is a fixed 0 or 1 use a reduced variant with less logic. The block has no state machine, so it defines no states and no transitions.

Top module: `isqrt_array`

## Requirements
- R1: For every input x, the output r satisfies r*r <= x < (r+1)*(r+1).
- R2: An input of 0 gives a root of 0.
- R3: The all-ones 8-bit input 255 gives the root 15.
- R4: Every perfect square k*k within range gives exactly k.
- R5: For k >= 1, the input k*k-1 gives k-1, the largest value just below a square boundary.
- R6: The output follows a change of input without any clock edge. It has no storage, so two different inputs applied inside one clock phase each give their own root.
- R7: Each row sets its root bit to 1 exactly when its remainder is at least its trial value. On 1 it passes on remainder minus trial, and on 0 it passes on the unchanged remainder. Example at the ports: 64 gives 8 and 63 gives 7.
- R8: With the input width parameter set to 32, the root output is 16 bits wide and R1 holds. This includes 0xFFFFFFFF giving 65535, 2^30 giving 32768 and 2^31 giving 46340.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | IN_W (default 8) | Unsigned radicand |
| root_out | output | IN_W/2 (default 4) | Integer square root of x_in, rounded down |

## Verification
The block has no state, so a wrong row shows up at once on the root output for the affected inputs, with no delay. A borrow wrongly formed in one row flips that root bit. It also passes a wrong remainder to every lower row, so the error spreads to the less significant bits. The bound r*r <= x < (r+1)^2 fails on its first affected input. The exhaustive sweep of all 256 narrow inputs therefore reaches every cell variant in every row. The square-boundary pairs catch an off-by-one in the borrow chain, and the wide instance checks that the row structure scales.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    typedef enum logic [1:0] {
        CELL_VAR  = 2'd0,
        CELL_ONE  = 2'd1,
        CELL_ZERO = 2'd2
    } cell_kind_e;

    // Kind of the subtractor cell at local bit j of row i.
    // Trial value (LSB first): 1, 0, then partial root bits, then zeros.
    function automatic cell_kind_e cell_kind(input int j, input int i, input int root_w);
        if (j == 0)
            return CELL_ONE;
        else if (j == 1)
            return CELL_ZERO;
        else if (j <= root_w - i)
            return CELL_VAR;
        else
            return CELL_ZERO;
    endfunction

endpackage

// File: rtl/isqrt_sm_cell.sv
module isqrt_sm_cell
    import isqrt_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_VAR
) (
    input  logic a_i,
    input  logic b_i,
    input  logic bin_i,
    input  logic take_i,
    output logic bout_o,
    output logic res_o
);

    logic diff;

    generate
        if (KIND == CELL_ONE) begin : g_one
            logic b_unused;
            assign b_unused = b_i;
            assign diff   = ~(a_i ^ bin_i);
            assign bout_o = ~a_i | bin_i;
        end else if (KIND == CELL_ZERO) begin : g_zero
            logic b_unused;
            assign b_unused = b_i;
            assign diff   = a_i ^ bin_i;
            assign bout_o = ~a_i & bin_i;
        end else begin : g_var
            assign diff   = a_i ^ b_i ^ bin_i;
            assign bout_o = (~a_i & b_i) | (~a_i & bin_i) | (b_i & bin_i);
        end
    endgenerate

    assign res_o = take_i ? diff : a_i;

endmodule

// File: rtl/isqrt_row.sv
module isqrt_row
    import isqrt_pkg::*;
#(
    parameter int IN_W = 8,
    parameter int ROW  = 0
) (
    input  logic [IN_W-1:0]   rem_in,
    input  logic [IN_W/2-1:0] q_in,
    output logic [IN_W-1:0]   rem_out,
    output logic [IN_W/2-1:0] q_out
);

    localparam int ROOT_W = IN_W / 2;
    localparam int BASE   = 2 * ROW;
    localparam int SW     = IN_W - BASE;

    logic [SW-1:0] trial;
    logic [SW:0]   borrow;
    logic [SW-1:0] upper_res;
    logic          take;

    assign borrow[0] = 1'b0;
    assign take      = ~borrow[SW];

    genvar j;
    generate
        for (j = 0; j < SW; j++) begin : g_cell
            localparam cell_kind_e K = cell_kind(j, ROW, ROOT_W);
            if (K == CELL_VAR) begin : g_tv
                assign trial[j] = q_in[ROW - 1 + j];
            end else if (K == CELL_ONE) begin : g_tv
                assign trial[j] = 1'b1;
            end else begin : g_tv
                assign trial[j] = 1'b0;
            end
            isqrt_sm_cell #(.KIND(K)) cell_i (
                .a_i    (rem_in[BASE + j]),
                .b_i    (trial[j]),
                .bin_i  (borrow[j]),
                .take_i (take),
                .bout_o (borrow[j+1]),
                .res_o  (upper_res[j])
            );
        end

        if (ROW == 0) begin : g_low
            assign rem_out = upper_res;
        end else begin : g_low
            assign rem_out = {upper_res, rem_in[BASE-1:0]};
        end
    endgenerate

    always_comb begin
        q_out      = q_in;
        q_out[ROW] = take;
    end

    // Checks for the row rule (R7)
    logic [IN_W-1:0] trial_full;
    assign trial_full = IN_W'(trial) << BASE;

    always_comb begin
        if (!take)
            assert_row_keep_R7: assert (rem_out == rem_in)
                else $error("row %0d changed remainder on borrow", ROW);
        if (take)
            assert_row_take_R7: assert (rem_out + trial_full == rem_in)
                else $error("row %0d remainder not reduced by trial", ROW);
    end

endmodule

// File: rtl/isqrt_array.sv
module isqrt_array #(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0]   x_in,
    output logic [IN_W/2-1:0] root_out
);

    localparam int ROOT_W = IN_W / 2;
    localparam int PW     = IN_W + 2;

    genvar i;
    generate
        for (i = ROOT_W - 1; i >= 0; i--) begin : g_row
            logic [IN_W-1:0]   rem_o;
            logic [ROOT_W-1:0] q_o;
            if (i == ROOT_W - 1) begin : g_src
                isqrt_row #(.IN_W(IN_W), .ROW(i)) row_i (
                    .rem_in  (x_in),
                    .q_in    ({ROOT_W{1'b0}}),
                    .rem_out (rem_o),
                    .q_out   (q_o)
                );
            end else begin : g_src
                isqrt_row #(.IN_W(IN_W), .ROW(i)) row_i (
                    .rem_in  (g_row[i+1].rem_o),
                    .q_in    (g_row[i+1].q_o),
                    .rem_out (rem_o),
                    .q_out   (q_o)
                );
            end
        end
    endgenerate

    assign root_out = g_row[0].q_o;

    logic [IN_W-1:0] rem_unused;
    assign rem_unused = g_row[0].rem_o;

    // Bounds of the floor root (R1)
    logic [PW-1:0] r_ext, r_next, sq_lo, sq_hi, x_ext;
    always_comb begin
        r_ext  = PW'(root_out);
        r_next = r_ext + PW'(1);
        sq_lo  = r_ext * r_ext;
        sq_hi  = r_next * r_next;
        x_ext  = PW'(x_in);
        assert_root_low_R1: assert (sq_lo <= x_ext)
            else $error("root squared exceeds input");
        assert_root_high_R1: assert (sq_hi > x_ext)
            else $error("next root squared not above input");
    end

endmodule

// File: tb/isqrt_array_tb_top.sv
module isqrt_array_tb_top;

    localparam time HALF = 2.5ns;

    typedef struct {
        logic [31:0] x;
        logic [15:0] exp;
        bit          wide;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  x_n = 8'd0;
    logic [3:0]  r_n;
    logic [31:0] x_w = 32'd0;
    logic [15:0] r_w;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    item_t sb_q[$];

    always #(HALF) clk = ~clk;

    isqrt_array #(.IN_W(8))  dut_i      (.x_in(x_n), .root_out(r_n));
    isqrt_array #(.IN_W(32)) dut_wide_i (.x_in(x_w), .root_out(r_w));

    function automatic logic [15:0] ref_root(input logic [31:0] x);
        longint lo = 0;
        longint hi = 65535;
        while (lo < hi) begin
            longint mid = (lo + hi + 1) / 2;
            if (mid * mid <= longint'(x)) lo = mid;
            else hi = mid - 1;
        end
        return 16'(lo);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input logic [31:0] x);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s x=%0d actual=%0d expected=%0d", tag, x, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] x, input bit wide, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        if (wide) x_w = x;
        else      x_n = x[7:0];
        it.x = x; it.exp = ref_root(x); it.wide = wide; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: pops one expected item per falling edge
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            if (it.wide) check(it.tag, 32'(r_w), 32'(it.exp), it.x);
            else         check(it.tag, 32'(r_n), 32'(it.exp), it.x);
        end
    end

    initial begin
        #(200000 * 5ns);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        // Reset state: zero input gives zero root (R2)
        check("R2", 32'(r_n), 32'd0, 32'd0);
        check("R2", 32'(r_w), 32'd0, 32'd0);
        rst_n = 1'b1;

        // Output follows input between clock edges (R6)
        @(negedge clk);
        x_n = 8'd200;
        #0.5ns;
        check("R6", 32'(r_n), 32'd14, 32'd200);
        x_n = 8'd16;
        #0.5ns;
        check("R6", 32'(r_n), 32'd4, 32'd16);

        // Row rule seen at the ports (R7)
        drive(32'd64, 1'b0, "R7");
        drive(32'd63, 1'b0, "R7");

        // Exhaustive narrow sweep (R1..R5)
        for (int v = 0; v < 256; v++) begin
            string tag;
            int k;
            k = int'(ref_root(32'(v)));
            if (v == 0)                         tag = "R2";
            else if (v == 255)                  tag = "R3";
            else if (k * k == v)                tag = "R4";
            else if ((k + 1) * (k + 1) == v + 1) tag = "R5";
            else                                tag = "R1";
            drive(32'(v), 1'b0, tag);
        end

        // Wide instance (R8)
        drive(32'd0,          1'b1, "R8");
        drive(32'd1,          1'b1, "R8");
        drive(32'hFFFF_FFFF,  1'b1, "R8");
        drive(32'hFFFE_0001,  1'b1, "R8");
        drive(32'hFFFE_0000,  1'b1, "R8");
        drive(32'h4000_0000,  1'b1, "R8");
        drive(32'h3FFF_FFFF,  1'b1, "R8");
        drive(32'h8000_0000,  1'b1, "R8");
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 64; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(lfsr, 1'b1, "R8");
        end

        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule